// File: doc/BRIEF.md
# I2C Read-Data Substitution Proxy

This block sits in line on a two-device I2C bus between one master and one slave. SCL stays a common wire and the block only observes it. SDA is cut in two, with one pin facing the master and one facing the slave. The block follows every transaction bit by bit. After each SCL falling edge it decides which side's SDA level is copied onto the other side, and it copies it as an open-drain pull-down, so no SCL delay is added.

The master uses only two transaction shapes. A register write is START, address with W, register, data, STOP. A register read is a pointer write made of START, address with W, register and STOP, followed by START, address with R, one data byte and STOP.

When a pointer write ends with STOP, the register number is reported as a single byte on the host transmit interface. The host loads replacement entries through the host receive interface. Each entry is a pair of bytes: the register number first, then the value. When the master later reads a register that holds a loaded entry, the block drives the stored byte to the master, MSB first, and releases the slave-side pin. The slave's byte does not reach the master.

Top module: `i2c_read_proxy`

## Requirements
- R1: While reset is asserted and right after it, neither SDA pin is pulled low (with the master side released), and host_tx_valid is 0.
- R2: During address, register and write-data bits, the slave-side pin copies the master-side level.
- R3: During the ACK bit that follows an address byte, or a byte the master writes, the master-side pin copies the slave-side level.
- R4: The direction and the driven bit change only after an SCL falling edge. Every level both sides see stays constant while SCL is high.
- R5: The master's ACK (0) or NACK (1) after a read-data byte reaches the slave side.
- R6: If an address match is followed by a write of exactly one byte and then STOP, host_tx_valid pulses for one cycle and host_tx_byte carries that byte. A write that also carries a data byte reports nothing.
- R7: Host receive bytes are taken in pairs. The first byte of a pair is the register number. The second is the replacement value, and it marks the entry valid.
- R8: In a matching read of a register with a valid entry, the master sees the stored value MSB first, and the slave-side pin stays released for the whole data byte.
- R9: In a matching read of a register with no valid entry, the master sees the slave's byte unchanged.
- R10: If the 7-bit address (the upper seven bits of the first byte, bit 0 set meaning read) differs from SLAVE_ADDR, nothing is reported and nothing is substituted. Data bits pass master to slave.
- R11: A START or STOP at any point, including in the middle of a byte, resynchronises the tracker. A START that comes a few clock cycles after a STOP is recognised.
- R12: A later pair for the same register replaces the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Shared SCL level |
| mst_sda_i | input | 1 | Master-side SDA level |
| mst_sda_pull | output | 1 | Pull master-side SDA low |
| slv_sda_i | input | 1 | Slave-side SDA level |
| slv_sda_pull | output | 1 | Pull slave-side SDA low |
| host_rx_valid | input | 1 | Host byte strobe (pair: register, then value) |
| host_rx_byte | input | 8 | Host byte |
| host_tx_valid | output | 1 | One-cycle strobe for a reported register |
| host_tx_byte | output | 8 | Reported register number |

## Verification
Four transaction shapes exercise the main function. A full register write checks that the slave sees every bit and that nothing is reported. A pointer write followed by a read with no entry checks the report and that the slave's byte reaches the master. The same read after an entry is loaded, and again after it is overwritten, separates substitution from passing the data through, because the slave and the replacement drive different bytes. A foreign address with a valid entry present must yield neither a report nor a substitution.

In addition, a START issued four cycles after STOP and a START that cuts an address byte in half check that the tracker re-arms. The level seen on both sides is compared at the SCL rising edge and again just before the falling edge.

// File: rtl/i2c_proxy_pkg.sv
package i2c_proxy_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // Which side drives in the current slot (1 = slave toward master).
  function automatic logic slot_is_s2m(input logic in_ack, input logic first_byte,
                                       input logic is_read, input logic addr_match);
    if (in_ack) return first_byte ? 1'b1 : !is_read;
    return !first_byte && is_read && addr_match;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] r, input logic b);
    return {r[BYTE_W-2:0], b};
  endfunction

  // A pointer write: address+W, one register byte, then STOP (at most one bit
  // of the third byte clocked, the STOP's own SCL rise).
  function automatic logic is_pointer_write(input logic [1:0] byte_idx, input logic in_ack,
                                            input int unsigned bits_seen,
                                            input logic is_read, input logic addr_match);
    return addr_match && !is_read && !in_ack && byte_idx == 2'd2 && bits_seen <= 1;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_cond,
  output logic stop_cond,
  output logic sda_now
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_p;
  logic [DEPTH-1:0] sda_p;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_raw;
          sda_p[g] <= sda_raw;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_p[g] <= 1'b1;
          sda_p[g] <= 1'b1;
        end else begin
          scl_p[g] <= scl_p[g-1];
          sda_p[g] <= sda_p[g-1];
        end
      end
    end
  end

  logic scl_c, scl_o, sda_c, sda_o;
  assign scl_c = scl_p[DEPTH-2];
  assign scl_o = scl_p[DEPTH-1];
  assign sda_c = sda_p[DEPTH-2];
  assign sda_o = sda_p[DEPTH-1];

  assign scl_rise   = scl_c & ~scl_o;
  assign scl_fall   = ~scl_c & scl_o;
  assign start_cond = scl_c & scl_o & ~sda_c & sda_o;
  assign stop_cond  = scl_c & scl_o & sda_c & ~sda_o;
  assign sda_now    = sda_c;
endmodule

// File: rtl/i2c_phase_tracker.sv
module i2c_phase_tracker
  import i2c_proxy_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_cond,
  input  logic              stop_cond,
  input  logic              sda_bit,
  output logic              dir_s2m,
  output logic              fall_evt,
  output logic              enter_rd,
  output logic              leave_data,
  output logic              report_stb,
  output logic [BYTE_W-1:0] reg_ptr
);
  logic              active, wait_fall, in_ack, is_read, addr_match;
  logic [CNT_W-1:0]  bit_cnt;
  logic [1:0]        byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              byte_full;

  assign byte_full  = (bit_cnt == CNT_W'(BYTE_W));
  assign fall_evt   = scl_fall && active && !wait_fall;
  assign leave_data = fall_evt && !in_ack && byte_full;
  assign enter_rd   = fall_evt && in_ack && is_read && addr_match;
  assign dir_s2m    = active && !wait_fall &&
                      slot_is_s2m(in_ack, byte_idx == 2'd0, is_read, addr_match);
  assign report_stb = stop_cond && active &&
                      is_pointer_write(byte_idx, in_ack, int'(bit_cnt), is_read, addr_match);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      wait_fall  <= 1'b0;
      in_ack     <= 1'b0;
      is_read    <= 1'b0;
      addr_match <= 1'b0;
      bit_cnt    <= '0;
      byte_idx   <= '0;
      shreg      <= '0;
      reg_ptr    <= '0;
    end else if (start_cond) begin
      active     <= 1'b1;
      wait_fall  <= 1'b1;
      in_ack     <= 1'b0;
      is_read    <= 1'b0;
      addr_match <= 1'b0;
      bit_cnt    <= '0;
      byte_idx   <= '0;
    end else if (stop_cond) begin
      active    <= 1'b0;
      wait_fall <= 1'b0;
      in_ack    <= 1'b0;
      bit_cnt   <= '0;
      byte_idx  <= '0;
    end else if (active) begin
      if (scl_rise && !wait_fall && !in_ack && !byte_full) begin
        shreg   <= shift_in(shreg, sda_bit);
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (scl_fall) begin
        if (wait_fall) begin
          wait_fall <= 1'b0;
        end else if (!in_ack && byte_full) begin
          in_ack <= 1'b1;
          if (byte_idx == 2'd0) begin
            addr_match <= (shreg[BYTE_W-1:1] == SLAVE_ADDR);
            is_read    <= shreg[0];
          end else if (byte_idx == 2'd1 && !is_read && addr_match) begin
            reg_ptr <= shreg;
          end
        end else if (in_ack) begin
          in_ack  <= 1'b0;
          bit_cnt <= '0;
          if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/override_table.sv
module override_table
  import i2c_proxy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] rd_key,
  output logic              rd_hit,
  output logic [BYTE_W-1:0] rd_val
);
  localparam int DEPTH = 1 << BYTE_W;

  logic [DEPTH-1:0]  valid_q;
  logic [BYTE_W-1:0] val_q [DEPTH];
  logic              have_key;
  logic [BYTE_W-1:0] key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      have_key <= 1'b0;
      key_q    <= '0;
    end else if (wr_valid) begin
      if (!have_key) begin
        key_q    <= wr_byte;
        have_key <= 1'b1;
      end else begin
        valid_q[key_q] <= 1'b1;
        have_key       <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && have_key) val_q[key_q] <= wr_byte;
  end

  assign rd_hit = valid_q[rd_key];
  assign rd_val = val_q[rd_key];
endmodule

// File: rtl/i2c_read_proxy.sv
module i2c_read_proxy
  import i2c_proxy_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h28,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              mst_sda_i,
  output logic              mst_sda_pull,
  input  logic              slv_sda_i,
  output logic              slv_sda_pull,
  input  logic              host_rx_valid,
  input  logic [BYTE_W-1:0] host_rx_byte,
  output logic              host_tx_valid,
  output logic [BYTE_W-1:0] host_tx_byte
);
  logic scl_rise, scl_fall, start_cond, stop_cond, sda_bit;
  logic dir_s2m, fall_evt, enter_rd, leave_data, report_stb;
  logic [BYTE_W-1:0] reg_ptr, tbl_val;
  logic tbl_hit;
  logic sub_on;
  logic [BYTE_W-1:0] sub_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(mst_sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond), .sda_now(sda_bit)
  );

  i2c_phase_tracker #(.SLAVE_ADDR(SLAVE_ADDR)) u_track (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_cond(start_cond), .stop_cond(stop_cond), .sda_bit(sda_bit),
    .dir_s2m(dir_s2m), .fall_evt(fall_evt), .enter_rd(enter_rd),
    .leave_data(leave_data), .report_stb(report_stb), .reg_ptr(reg_ptr)
  );

  override_table u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_valid(host_rx_valid), .wr_byte(host_rx_byte),
    .rd_key(reg_ptr), .rd_hit(tbl_hit), .rd_val(tbl_val)
  );

  // Replacement shifter: loaded on the fall that opens a read-data slot,
  // advanced on each later fall, dropped on the fall that opens the ACK slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_on <= 1'b0;
      sub_q  <= '0;
    end else if (start_cond || stop_cond) begin
      sub_on <= 1'b0;
    end else if (enter_rd) begin
      sub_on <= tbl_hit;
      sub_q  <= tbl_val;
    end else if (sub_on && fall_evt) begin
      if (leave_data) sub_on <= 1'b0;
      else            sub_q  <= sub_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_tx_valid <= 1'b0;
      host_tx_byte  <= '0;
    end else begin
      host_tx_valid <= report_stb;
      if (report_stb) host_tx_byte <= reg_ptr;
    end
  end

  assign mst_sda_pull = dir_s2m && (sub_on ? !sub_q[BYTE_W-1] : !slv_sda_i);
  assign slv_sda_pull = !dir_s2m && !mst_sda_i;
endmodule

// File: rtl/i2c_proxy_checks.sv
module i2c_proxy_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_s2m,
  input logic       fall_evt,
  input logic       start_cond,
  input logic       stop_cond,
  input logic       sub_on,
  input logic [7:0] sub_q,
  input logic       slv_sda_pull,
  input logic       host_tx_valid
);
  // R4: direction moves only right after a falling edge, START or STOP
  p_dir_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dir_s2m) |-> $past(fall_evt || start_cond || stop_cond));

  // R4: replacement bits change only on a falling edge
  p_sub_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sub_q));

  // R11: STOP re-arms: back to master-to-slave, no substitution
  p_stop_rearm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cond |=> (!dir_s2m && !sub_on));

  // R8: substitution only while slave side is released and steering is toward master
  p_sub_in_s2m_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_on |-> (dir_s2m && !slv_sda_pull));

  // R6: a report follows a STOP
  p_report_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_valid |-> $past(stop_cond));
endmodule

bind i2c_read_proxy i2c_proxy_checks u_chk (
  .clk(clk), .rst_n(rst_n), .dir_s2m(dir_s2m), .fall_evt(fall_evt),
  .start_cond(start_cond), .stop_cond(stop_cond), .sub_on(sub_on),
  .sub_q(sub_q), .slv_sda_pull(slv_sda_pull), .host_tx_valid(host_tx_valid)
);

// File: tb/tb_i2c_read_proxy.sv
module tb_i2c_read_proxy;
  localparam logic [6:0] DEV = 7'h28;
  localparam logic [6:0] OTHER = 7'h31;
  localparam int HP = 48;
  localparam int Q  = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1, m_drv = 1'b1, s_drv = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic m_pull, s_pull, tx_valid;
  logic [7:0] tx_byte;
  logic m_line, s_line;

  assign s_line = s_drv & ~s_pull;
  assign m_line = m_drv & ~m_pull;

  i2c_read_proxy #(.SLAVE_ADDR(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .mst_sda_i(m_drv), .mst_sda_pull(m_pull),
    .slv_sda_i(s_line), .slv_sda_pull(s_pull), .host_rx_valid(rx_valid),
    .host_rx_byte(rx_byte), .host_tx_valid(tx_valid), .host_tx_byte(tx_byte)
  );

  int checks = 0, fails = 0, hold_bad = 0, tx_count = 0;
  logic [7:0] tx_last = 8'h00;
  bit done = 1'b0;

  always @(negedge clk) if (tx_valid) begin tx_count++; tx_last = tx_byte; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_slot(input logic mb, input logic sb, output logic ms, output logic ss);
    wait_cyc(Q); m_drv = mb; s_drv = sb;
    wait_cyc(HP - Q); scl = 1'b1;
    wait_cyc(Q); ms = m_line; ss = s_line;
    wait_cyc(HP - Q - 2);
    if (m_line !== ms || s_line !== ss) hold_bad++;
    wait_cyc(2); scl = 1'b0;
  endtask

  task automatic bus_start(input int gap);
    wait_cyc(gap); m_drv = 1'b0; wait_cyc(HP); scl = 1'b0;
  endtask

  task automatic bus_restart();
    wait_cyc(Q); m_drv = 1'b1; s_drv = 1'b1;
    wait_cyc(HP - Q); scl = 1'b1; wait_cyc(HP); m_drv = 1'b0; wait_cyc(HP); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_cyc(Q); m_drv = 1'b0; s_drv = 1'b1;
    wait_cyc(HP - Q); scl = 1'b1; wait_cyc(HP); m_drv = 1'b1;
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic s_ack, output logic [7:0] s_got, output logic m_ack_got);
    logic ms, ss;
    for (int i = 7; i >= 0; i--) begin bit_slot(b[i], 1'b1, ms, ss); s_got[i] = ss; end
    bit_slot(1'b1, ~s_ack, ms, ss); m_ack_got = ms;
  endtask

  task automatic rd_byte(input logic [7:0] sb, input logic m_ack, output logic [7:0] m_got,
                         output logic [7:0] s_got, output logic s_ack_got);
    logic ms, ss;
    for (int i = 7; i >= 0; i--) begin bit_slot(1'b1, sb[i], ms, ss); m_got[i] = ms; s_got[i] = ss; end
    bit_slot(~m_ack, 1'b1, ms, ss); s_ack_got = ss;
  endtask

  task automatic ptr_write(input logic [6:0] a, input logic [7:0] r, input int gap);
    logic [7:0] sg; logic ak;
    bus_start(gap);
    wr_byte({a, 1'b0}, 1'b1, sg, ak);
    wr_byte(r, 1'b1, sg, ak);
    bus_stop();
  endtask

  task automatic read_txn(input logic [6:0] a, input logic [7:0] sb, input logic m_ack, input int gap,
                          output logic [7:0] m_got, output logic [7:0] s_got, output logic s_ack_got);
    logic [7:0] sg; logic ak;
    bus_start(gap);
    wr_byte({a, 1'b1}, 1'b1, sg, ak);
    rd_byte(sb, m_ack, m_got, s_got, s_ack_got);
    bus_stop();
  endtask

  task automatic load_entry(input logic [7:0] k, input logic [7:0] v);
    @(negedge clk); rx_valid = 1'b1; rx_byte = k;
    @(negedge clk); rx_byte = v;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk(m_pull == 1'b0 && s_pull == 1'b0, "R1 pulls in reset", {m_pull, s_pull}, 0);
    chk(tx_valid == 1'b0, "R1 tx idle in reset", tx_valid, 0);
    rst_n = 1'b1; wait_cyc(5);
    chk(m_pull == 1'b0 && s_pull == 1'b0 && tx_valid == 1'b0, "R1 after reset", {tx_valid, m_pull, s_pull}, 0);
  endtask

  task automatic test_reg_write();
    logic [7:0] sg; logic ak; int c0;
    c0 = tx_count; hold_bad = 0;
    bus_start(HP);
    wr_byte({DEV, 1'b0}, 1'b1, sg, ak);
    chk(sg == {DEV, 1'b0}, "R2 address to slave", sg, {DEV, 1'b0});
    chk(ak == 1'b0, "R3 slave ack to master", ak, 0);
    wr_byte(8'h12, 1'b1, sg, ak);
    chk(sg == 8'h12, "R2 register to slave", sg, 8'h12);
    wr_byte(8'hA5, 1'b1, sg, ak);
    chk(sg == 8'hA5, "R2 data to slave", sg, 8'hA5);
    chk(ak == 1'b0, "R3 data ack to master", ak, 0);
    bus_stop(); wait_cyc(HP);
    chk(tx_count == c0, "R6 full write not reported", tx_count, c0);
    chk(hold_bad == 0, "R4 levels steady while SCL high", hold_bad, 0);
  endtask

  task automatic test_read_pass();
    logic [7:0] mg, sgot; logic sa; int c0;
    c0 = tx_count;
    ptr_write(DEV, 8'h12, HP); wait_cyc(8);
    chk(tx_count == c0 + 1, "R6 pointer write reported once", tx_count, c0 + 1);
    chk(tx_last == 8'h12, "R6 reported register", tx_last, 8'h12);
    read_txn(DEV, 8'h5A, 1'b0, 4, mg, sgot, sa);
    chk(mg == 8'h5A, "R9 slave byte passes", mg, 8'h5A);
    chk(sa == 1'b1, "R5 master NACK reaches slave", sa, 1);
    wait_cyc(HP);
  endtask

  task automatic test_override();
    logic [7:0] mg, sgot; logic sa;
    hold_bad = 0;
    load_entry(8'h12, 8'hC3);
    ptr_write(DEV, 8'h12, HP);
    read_txn(DEV, 8'h5A, 1'b1, 4, mg, sgot, sa);
    chk(mg == 8'hC3, "R7 R8 replacement seen by master", mg, 8'hC3);
    chk(sgot == 8'h5A, "R8 slave side released", sgot, 8'h5A);
    chk(sa == 1'b0, "R5 master ACK reaches slave", sa, 0);
    chk(hold_bad == 0, "R4 replacement bits steady", hold_bad, 0);
    load_entry(8'h12, 8'h3C);
    ptr_write(DEV, 8'h12, HP);
    read_txn(DEV, 8'h5A, 1'b0, HP, mg, sgot, sa);
    chk(mg == 8'h3C, "R12 entry overwritten", mg, 8'h3C);
    ptr_write(DEV, 8'h13, HP);
    read_txn(DEV, 8'h96, 1'b0, HP, mg, sgot, sa);
    chk(mg == 8'h96, "R9 unloaded register passes", mg, 8'h96);
    wait_cyc(HP);
  endtask

  task automatic test_foreign();
    logic [7:0] mg, sgot, sg; logic sa, ak; int c0;
    c0 = tx_count;
    bus_start(HP);
    wr_byte({OTHER, 1'b0}, 1'b1, sg, ak);
    wr_byte(8'h12, 1'b1, sg, ak);
    chk(sg == 8'h12, "R10 foreign register passes to slave", sg, 8'h12);
    bus_stop(); wait_cyc(8);
    chk(tx_count == c0, "R10 foreign not reported", tx_count, c0);
    read_txn(OTHER, 8'h5A, 1'b0, HP, mg, sgot, sa);
    chk(mg == 8'hFF, "R10 no substitution, master-to-slave data", mg, 8'hFF);
    wait_cyc(HP);
  endtask

  task automatic test_abort();
    logic [7:0] sg, mg, sgot; logic ak, ms, ss, sa; int c0;
    c0 = tx_count;
    load_entry(8'h44, 8'h77);
    bus_start(HP);
    for (int i = 0; i < 4; i++) bit_slot(i[0], 1'b1, ms, ss);
    bus_restart();
    wr_byte({DEV, 1'b0}, 1'b1, sg, ak);
    wr_byte(8'h44, 1'b1, sg, ak);
    bus_stop(); wait_cyc(8);
    chk(tx_count == c0 + 1 && tx_last == 8'h44, "R11 restart mid-byte resyncs", tx_last, 8'h44);
    read_txn(DEV, 8'h00, 1'b0, 4, mg, sgot, sa);
    chk(mg == 8'h77, "R11 short gap START then R8 substitution", mg, 8'h77);
    wait_cyc(HP);
  endtask

  initial begin
    wait_cyc(5);
    test_reset();
    test_reg_write();
    test_read_pass();
    test_override();
    test_foreign();
    test_abort();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule